// File: doc/BRIEF.md
# Power Mode Sequencer with Wake Logging

This block decides the power state of a small CPU subsystem. Software, while running, asks for one of four low-power states by writing a request: sleep, standby, snooze or deep sleep. The block then drops the CPU clock enable, and for the deeper states the CPU power enable as well. It watches a set of wake-event lines, each filtered by the sources that the current state accepts. When an accepted event arrives, it returns to active, raises exactly one resume-type pulse, and records the source in a sticky wake-cause register. The pulse is a cold reboot from deep sleep, a fast reboot from standby, and continued execution from sleep and snooze. Software clears that register by writing ones.

Snooze keeps the CPU clock off but opens a beacon-receive window on its own at a programmable interval, with no software involvement. A low chip-enable input overrides everything and forces the off state. When chip-enable returns high, the block leaves the off state through a cold reboot.

Wake lines are asynchronous. Each one goes through a two-flop synchronizer and a rising-edge detector, so a line that stays high counts as one event.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the state is as follows: `mode` reads 0 (active), both CPU enables are 1, and `wake_reason`, the three resume pulses and `beacon_win` are all 0.
- R2: Mode codes are 0 active, 1 sleep, 2 standby, 3 snooze, 4 deep sleep, 5 off. While active, a request (`req_valid`=1) carrying code 1 to 4 sets `mode` to that code at the next clock edge. Codes 0, 5, 6 and 7 are ignored. Any request made while not active is ignored.
- R3: `cpu_clk_en` is 1 only in active. `cpu_pwr_en` is 1 in active, sleep and snooze, and 0 in standby, deep sleep and off.
- R4: If `chip_en` is 0 at a clock edge, `mode` becomes 5 at that edge from any state, with no resume pulse. While off, wake lines are ignored and not recorded. In off with `chip_en` high, the next edge returns to active and raises `reboot_pulse`.
- R5: Deep sleep accepts only `wake_in` bits 12 to 6. Any other bit, and `wake_pwm`, neither wakes the block nor is recorded.
- R6: Sleep, standby and snooze accept `wake_in` bits 12..5, 3, 1 and 0, and also `wake_pwm`. `wake_pwm` wakes the block but records no bit.
- R7: An accepted wake sets `mode` to 0 and raises, for one cycle, exactly one pulse: `reboot_pulse` from deep sleep, `fast_reboot_pulse` from standby, or `resume_pulse` from sleep or snooze.
- R8: The `wake_reason` bit map is as follows: bits 12..9 are always-on GPIO 3..0, bit 8 is RTC, bit 7 is comparator, bit 6 is always-on timer, bit 5 is UART, bit 3 is WLAN, bit 1 is power-domain GPIO, and bit 0 is general timer 0. Bits 4 and 2 always read 0. Accepted sources set their bits in the same cycle as the pulse, and the bits stay set.
- R9: A clock edge with `clr_valid`=1 clears every `wake_reason` bit whose `clr_mask` bit is 1. If the same bit is also being set at that edge, the set wins.
- R10: A wake is a rising edge on a wake line. The pulse appears 3 clock edges after the edge at which the raised line is first sampled. A line held high does not cause another wake.
- R11: In snooze, `beacon_win` is low for `snz_period`+1 cycles and then high for `snz_window` cycles (1 cycle if the window is 0), and this pattern repeats. Outside snooze it is 0.
- R12: Wake events that arrive while active are ignored and not recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_en | input | 1 | Chip enable; low forces the off state |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 3 | Requested mode code |
| wake_in | input | 13 | Wake lines, one per cause bit position |
| wake_pwm | input | 1 | PWM wake line (no cause bit) |
| clr_valid | input | 1 | Write-one-to-clear strobe for wake causes |
| clr_mask | input | 13 | Bits to clear |
| snz_period | input | SNZ_PW | Snooze idle length in cycles, minus one |
| snz_window | input | SNZ_WW | Beacon window length in cycles |
| mode | output | 3 | Current mode code |
| cpu_clk_en | output | 1 | CPU clock enable |
| cpu_pwr_en | output | 1 | CPU power enable |
| reboot_pulse | output | 1 | Cold reboot request |
| fast_reboot_pulse | output | 1 | Fast reboot request |
| resume_pulse | output | 1 | Continue-execution request |
| beacon_win | output | 1 | Beacon receive window |
| wake_reason | output | 13 | Sticky wake causes |

## Verification
The bench mixes random wake vectors, which include the unused bits 4 and 2 and sources that only the shallow modes accept, with all four low-power modes. A design that used one source mask for every mode would wake from deep sleep on a UART or PWM line and log it. A design that matched the wrong pulse to the wrong mode would reboot a sleeping CPU. Directed cases cover the following:
- A held-high line. An edge detector that actually senses levels would wake the block again straight after it re-enters sleep.
- A clear that lands in the same edge as a set. Here a wrong priority loses a cause.
- Chip-enable dropping while a wake is pending, which must leave the cause register untouched.
- The exact beacon low and high lengths, where an off-by-one in the snooze counter shows up at once.

// File: rtl/pms_pkg.sv
package pms_pkg;
  localparam int WAKE_W = 13;

  typedef enum logic [2:0] {
    PM_ACTIVE  = 3'd0,
    PM_SLEEP   = 3'd1,
    PM_STANDBY = 3'd2,
    PM_SNOOZE  = 3'd3,
    PM_DEEP    = 3'd4,
    PM_OFF     = 3'd5
  } pm_mode_e;

  // always-on GPIO, RTC, comparator, always-on timer
  localparam logic [WAKE_W-1:0] DEEP_SRC = 13'h1FC0;
  // plus UART (5), WLAN (3), power-domain GPIO (1), general timer 0 (0)
  localparam logic [WAKE_W-1:0] FULL_SRC = 13'h1FEB;

  function automatic logic [WAKE_W-1:0] src_allow(pm_mode_e m);
    case (m)
      PM_DEEP:                       src_allow = DEEP_SRC;
      PM_SLEEP, PM_STANDBY, PM_SNOOZE: src_allow = FULL_SRC;
      default:                       src_allow = '0;
    endcase
  endfunction

  function automatic logic pwm_allow(pm_mode_e m);
    pwm_allow = (m == PM_SLEEP) || (m == PM_STANDBY) || (m == PM_SNOOZE);
  endfunction
endpackage

// File: rtl/pms_sync_edge.sv
module pms_sync_edge #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] rise
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/pms_snooze_timer.sv
module pms_snooze_timer #(
  parameter int PW = 16,
  parameter int WW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] period,
  input  logic [WW-1:0] window,
  output logic          win
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic [WW-1:0] wc_q, wc_d;
  logic          in_q, in_d;

  always_comb begin
    cnt_d = cnt_q;
    wc_d  = wc_q;
    in_d  = in_q;
    if (!run) begin
      cnt_d = period;
      wc_d  = '0;
      in_d  = 1'b0;
    end else if (!in_q) begin
      if (cnt_q == '0) begin
        in_d = 1'b1;
        wc_d = window;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else begin
      if (wc_q <= WW'(1)) begin
        in_d  = 1'b0;
        cnt_d = period;
      end else begin
        wc_d = wc_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wc_q  <= '0;
      in_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      wc_q  <= wc_d;
      in_q  <= in_d;
    end
  end

  assign win = in_q & run;
endmodule

// File: rtl/pms_wake_log.sv
module pms_wake_log #(
  parameter int          W     = 13,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_v,
  input  logic         clr_en,
  input  logic [W-1:0] clr_v,
  output logic [W-1:0] reason
);
  logic [W-1:0] reason_d;

  always_comb begin
    reason_d = reason;
    if (clr_en) reason_d = reason_d & ~clr_v;
    reason_d = (reason_d | set_v) & VALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reason <= '0;
    else        reason <= reason_d;
  end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int SNZ_PW = 16,
  parameter int SNZ_WW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              req_valid,
  input  logic [2:0]        req_mode,
  input  logic [WAKE_W-1:0] wake_in,
  input  logic              wake_pwm,
  input  logic              clr_valid,
  input  logic [WAKE_W-1:0] clr_mask,
  input  logic [SNZ_PW-1:0] snz_period,
  input  logic [SNZ_WW-1:0] snz_window,
  output logic [2:0]        mode,
  output logic              cpu_clk_en,
  output logic              cpu_pwr_en,
  output logic              reboot_pulse,
  output logic              fast_reboot_pulse,
  output logic              resume_pulse,
  output logic              beacon_win,
  output logic [WAKE_W-1:0] wake_reason
);
  localparam int SYNC_W = WAKE_W + 1;

  // reset: asserted asynchronously, released after two edges
  logic [1:0] rs_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  logic [SYNC_W-1:0] rise_all;
  logic [WAKE_W-1:0] rise_src;
  logic              rise_pwm;

  pms_sync_edge #(.W(SYNC_W)) u_sync (
    .clk  (clk),
    .rst_n(rst_core_n),
    .d_in ({wake_pwm, wake_in}),
    .rise (rise_all)
  );
  assign rise_src = rise_all[WAKE_W-1:0];
  assign rise_pwm = rise_all[WAKE_W];

  pm_mode_e mode_q, mode_d;
  logic     rbt_q, rbt_d, frb_q, frb_d, rsm_q, rsm_d;
  logic     low_pwr, wake_ok, wake_hit;
  logic [WAKE_W-1:0] log_set;

  assign low_pwr  = (mode_q == PM_SLEEP) || (mode_q == PM_STANDBY) ||
                    (mode_q == PM_SNOOZE) || (mode_q == PM_DEEP);
  assign wake_ok  = chip_en && low_pwr;
  assign log_set  = wake_ok ? (rise_src & src_allow(mode_q)) : '0;
  assign wake_hit = wake_ok && ((|(rise_src & src_allow(mode_q))) ||
                                (rise_pwm && pwm_allow(mode_q)));

  always_comb begin
    mode_d = mode_q;
    rbt_d  = 1'b0;
    frb_d  = 1'b0;
    rsm_d  = 1'b0;
    if (!chip_en) begin
      mode_d = PM_OFF;
    end else begin
      case (mode_q)
        PM_ACTIVE: begin
          if (req_valid && (req_mode >= 3'd1) && (req_mode <= 3'd4))
            mode_d = pm_mode_e'(req_mode);
        end
        PM_OFF: begin
          mode_d = PM_ACTIVE;
          rbt_d  = 1'b1;
        end
        default: begin
          if (wake_hit) begin
            mode_d = PM_ACTIVE;
            rbt_d  = (mode_q == PM_DEEP);
            frb_d  = (mode_q == PM_STANDBY);
            rsm_d  = (mode_q == PM_SLEEP) || (mode_q == PM_SNOOZE);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      mode_q <= PM_ACTIVE;
      rbt_q  <= 1'b0;
      frb_q  <= 1'b0;
      rsm_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      rbt_q  <= rbt_d;
      frb_q  <= frb_d;
      rsm_q  <= rsm_d;
    end
  end

  pms_wake_log #(.W(WAKE_W), .VALID(FULL_SRC)) u_log (
    .clk   (clk),
    .rst_n (rst_core_n),
    .set_v (log_set),
    .clr_en(clr_valid),
    .clr_v (clr_mask),
    .reason(wake_reason)
  );

  logic snz_win;
  pms_snooze_timer #(.PW(SNZ_PW), .WW(SNZ_WW)) u_snz (
    .clk   (clk),
    .rst_n (rst_core_n),
    .run   (mode_q == PM_SNOOZE),
    .period(snz_period),
    .window(snz_window),
    .win   (snz_win)
  );

  assign mode              = mode_q;
  assign cpu_clk_en        = (mode_q == PM_ACTIVE);
  assign cpu_pwr_en        = (mode_q == PM_ACTIVE) || (mode_q == PM_SLEEP) ||
                             (mode_q == PM_SNOOZE);
  assign reboot_pulse      = rbt_q;
  assign fast_reboot_pulse = frb_q;
  assign resume_pulse      = rsm_q;
  assign beacon_win        = snz_win;
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk (
  input logic        clk,
  input logic        rst_core_n,
  input logic        chip_en,
  input logic        clr_valid,
  input logic [2:0]  mode,
  input logic        cpu_clk_en,
  input logic        cpu_pwr_en,
  input logic        reboot_pulse,
  input logic        fast_reboot_pulse,
  input logic        resume_pulse,
  input logic        beacon_win,
  input logic [12:0] wake_reason
);
  // R7
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0({reboot_pulse, fast_reboot_pulse, resume_pulse}));

  // R7
  pulse_in_active_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (reboot_pulse || fast_reboot_pulse || resume_pulse) |-> (mode == 3'd0));

  // R7
  fast_from_standby_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    fast_reboot_pulse |-> ($past(mode) == 3'd2));

  // R4
  off_entry_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !chip_en |=> (mode == 3'd5));

  // R3
  clk_needs_pwr_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    cpu_clk_en |-> cpu_pwr_en);

  // R8
  spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wake_reason[4] == 1'b0) && (wake_reason[2] == 1'b0));

  // R12
  reason_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (($past(mode) == 3'd0) && !$past(clr_valid)) |-> $stable(wake_reason));

  // R11
  beacon_snooze_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    beacon_win |-> (mode == 3'd3));
endmodule

bind pwr_mode_seq pwr_mode_seq_chk u_chk (.*);

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chip_en = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_mode = 3'd0;
  logic [12:0] wake_in = '0;
  logic        wake_pwm = 1'b0;
  logic        clr_valid = 1'b0;
  logic [12:0] clr_mask = '0;
  logic [15:0] snz_period = 16'd200;
  logic [7:0]  snz_window = 8'd4;
  logic [2:0]  mode;
  logic        cpu_clk_en, cpu_pwr_en, reboot_pulse, fast_reboot_pulse, resume_pulse, beacon_win;
  logic [12:0] wake_reason;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int cur = 0;
  logic [12:0] exp_rsn = '0;

  always #2 clk = ~clk;

  pwr_mode_seq i_pwr_mode_seq (.*);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [12:0] f_allow(input int m);
    if (m == 4) return 13'h1FC0;
    if (m >= 1 && m <= 3) return 13'h1FEB;
    return 13'h0;
  endfunction

  function automatic bit f_pwm(input int m);
    return (m >= 1 && m <= 3);
  endfunction

  function automatic logic [2:0] f_pulse(input int m);
    if (m == 4) return 3'b100;
    if (m == 2) return 3'b010;
    return 3'b001;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_enables(input string rq);
    chk(cpu_clk_en == (cur == 0), rq, cpu_clk_en, cur == 0);
    chk(cpu_pwr_en == (cur == 0 || cur == 1 || cur == 3), rq, cpu_pwr_en,
        cur == 0 || cur == 1 || cur == 3);
  endtask

  task automatic do_req(input int m);
    req_valid = 1'b1;
    req_mode  = 3'(m);
    step(1);
    req_valid = 1'b0;
    if (cur == 0 && m >= 1 && m <= 4) cur = m;
    chk(mode == 3'(cur), "R2", mode, cur);
    check_enables("R3");
  endtask

  task automatic do_wake(input logic [12:0] v, input bit p);
    logic [12:0] al;
    bit hit;
    string rq;
    al  = f_allow(cur);
    hit = (|(v & al)) || (p && f_pwm(cur));
    rq  = (cur == 0) ? "R12" : ((cur == 4) ? "R5" : "R6");
    wake_in = v;
    wake_pwm = p;
    step(3);
    if (hit) begin
      chk(mode == 3'd0, rq, mode, 0);
      chk({reboot_pulse, fast_reboot_pulse, resume_pulse} == f_pulse(cur), "R7",
          {reboot_pulse, fast_reboot_pulse, resume_pulse}, f_pulse(cur));
      exp_rsn |= v & al;
      chk(wake_reason == exp_rsn, "R8", wake_reason, exp_rsn);
      cur = 0;
      step(1);
      chk({reboot_pulse, fast_reboot_pulse, resume_pulse} == 3'b000, "R7",
          {reboot_pulse, fast_reboot_pulse, resume_pulse}, 0);
    end else begin
      chk(mode == 3'(cur), rq, mode, cur);
      chk({reboot_pulse, fast_reboot_pulse, resume_pulse} == 3'b000, rq,
          {reboot_pulse, fast_reboot_pulse, resume_pulse}, 0);
      chk(wake_reason == exp_rsn, rq, wake_reason, exp_rsn);
    end
    wake_in = '0;
    wake_pwm = 1'b0;
    step(3);
  endtask

  task automatic do_clr(input logic [12:0] m);
    clr_valid = 1'b1;
    clr_mask = m;
    step(1);
    clr_valid = 1'b0;
    exp_rsn &= ~m;
    chk(wake_reason == exp_rsn, "R9", wake_reason, exp_rsn);
  endtask

  initial begin
    int lo, hi, lo2;
    void'($urandom(32'h5EED));
    step(3);
    rst_n = 1'b1;
    step(4);
    // R1 reset state
    chk(mode == 3'd0 && cpu_clk_en && cpu_pwr_en, "R1", mode, 0);
    chk(wake_reason == 13'h0 && !beacon_win, "R1", wake_reason, 0);
    chk({reboot_pulse, fast_reboot_pulse, resume_pulse} == 3'b000, "R1",
        {reboot_pulse, fast_reboot_pulse, resume_pulse}, 0);

    // R2 illegal codes ignored while active
    do_req(0); do_req(5); do_req(6); do_req(7);
    // R12 wakes while active ignored
    do_wake(13'h1FFF, 1'b1);
    // R2 request while asleep ignored
    do_req(1);
    do_req(2);
    do_wake(13'h0008, 1'b0);  // WLAN from sleep
    // R5 deep sleep rejects UART, WLAN, PWM
    do_req(4);
    do_wake(13'h0020, 1'b1);
    do_wake(13'h000B, 1'b0);
    do_wake(13'h0100, 1'b0);  // RTC wakes deep sleep
    // R6 PWM wakes standby without a cause bit
    do_req(2);
    do_wake(13'h0000, 1'b1);
    // R8 spare bits alone do not wake
    do_req(1);
    do_wake(13'h0014, 1'b0);
    do_wake(13'h1000, 1'b0);
    do_clr(13'h1FFF);

    // R9 set wins over a clear in the same edge
    do_req(1);
    wake_in = 13'h0001;
    step(2);
    clr_valid = 1'b1;
    clr_mask = 13'h0001;
    step(1);
    clr_valid = 1'b0;
    cur = 0;
    exp_rsn = 13'h0001;
    chk(wake_reason == exp_rsn, "R9", wake_reason, exp_rsn);
    chk(resume_pulse == 1'b1, "R7", resume_pulse, 1);

    // R10 held line does not retrigger
    do_req(1);
    step(6);
    chk(mode == 3'd1, "R10", mode, 1);
    wake_in = '0;
    step(3);
    do_wake(13'h0001, 1'b0);

    // R4 off state
    do_req(2);
    chip_en = 1'b0;
    wake_in = 13'h0100;
    step(1);
    chk(mode == 3'd5 && !cpu_pwr_en && !cpu_clk_en, "R4", mode, 5);
    chk({reboot_pulse, fast_reboot_pulse, resume_pulse} == 3'b000, "R4",
        {reboot_pulse, fast_reboot_pulse, resume_pulse}, 0);
    step(4);
    chk(mode == 3'd5 && wake_reason == exp_rsn, "R4", wake_reason, exp_rsn);
    chip_en = 1'b1;
    wake_in = '0;
    step(1);
    chk(mode == 3'd0 && reboot_pulse, "R4", {mode, reboot_pulse}, 1);
    cur = 0;
    step(3);

    // R11 snooze beacon timing
    snz_period = 16'd5;
    snz_window = 8'd3;
    do_req(3);
    lo = 0; hi = 0; lo2 = 0;
    while (!beacon_win && lo < 50) begin lo++; step(1); end
    while (beacon_win && hi < 50) begin hi++; step(1); end
    while (!beacon_win && lo2 < 50) begin lo2++; step(1); end
    chk(lo == 6, "R11", lo, 6);
    chk(hi == 3, "R11", hi, 3);
    chk(lo2 == 6, "R11", lo2, 6);
    do_wake(13'h0100, 1'b0);
    chk(!beacon_win, "R11", beacon_win, 0);
    snz_period = 16'd200;

    // random mix
    for (int i = 0; i < 40; i++) begin
      int m;
      logic [12:0] v;
      m = 1 + int'($urandom % 4);
      do_req(m);
      v = 13'($urandom);
      if ($urandom % 3 == 0) v = v & 13'h003F;
      do_wake(v, 1'($urandom % 2));
      if (cur != 0) do_wake(13'h0200, 1'b0);
      if ($urandom % 4 == 0) do_clr(13'($urandom));
    end

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule